// File: doc/BRIEF.md
# Prioritized Memory and I/O Chip-Select Decoder

This block turns each CPU bus cycle into at most one active-low chip select out of four channels. The address bus is 24 bits wide, and memory and I/O cycles are two separate spaces. Each channel is set up through a small register write port, with three registers per channel: control, lower bound and upper bound.

In memory mode, a channel claims a cycle when the top address byte lies between its two bounds, inclusive. In I/O mode, a channel claims a cycle when address bits 11:4 equal its lower bound. An I/O match is only possible while an I/O instruction runs, and never when the low address byte falls in the on-chip peripheral window at 80h to FFh. If several channels match, the lowest-numbered one wins. An I/O select also pulls the I/O request output low.

Each channel has a wait-state count. At the start of a bus cycle, the winner's count is loaded, and the wait output is held for that many clocks. All outputs are registered and appear one clock after the edge that samples the request.

Top module: `csd_top`

## Requirements
- R1: After reset, every chip select and the I/O request output are high and the wait output is low. Channel 0 comes out of reset enabled in memory mode with bounds 00h and FFh, so any memory request selects it. All other channel registers reset to 00h.
- R2: A channel whose enable bit (control bit 3) is 0 never drives its chip select low, even when its bounds cover the address.
- R3: A memory-mode channel (control bit 4 = 0) matches a memory request when addr[23:16] lies in [lower, upper], bounds included. An I/O-mode channel never answers a memory request.
- R4: An I/O-mode channel (control bit 4 = 1) matches an I/O request only while the I/O-instruction input is high and addr[11:4] equals its lower bound. addr[23:12] plays no part in this match.
- R5: No chip select is driven low for an I/O request whose addr[7:0] is 80h or above.
- R6: When several channels match, only the lowest-numbered one drives its chip select low. At most one chip select is ever low.
- R7: The I/O request output is low exactly when an I/O-mode channel is selected. It stays high while a memory-mode channel is selected.
- R8: Control bits 7:5 hold a wait count N. On the first clock edge where a request strobe becomes active, the winner's N is loaded. The wait output is then high for exactly N clocks and then falls. When N is 0, the wait output stays low.
- R9: In any cycle where no request strobe is active, all chip selects and the I/O request output are high at the next clock.
- R10: Registers are written when wr_en is high. wr_addr[3:2] selects the channel, and wr_addr[1:0] selects the register: 0 for control, 1 for lower bound, 2 for upper bound. Code 3 is ignored. A write that lands on the same edge as a decode affects only later decodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Channel (bits 3:2) and register select (bits 1:0) |
| wr_data | input | 8 | Register write data |
| addr | input | 24 | CPU address bus |
| mem_req | input | 1 | Memory request strobe, active high |
| io_req | input | 1 | I/O request strobe, active high |
| io_instr | input | 1 | High while an I/O instruction executes |
| cs_n | output | 4 | Active-low chip selects, bit n for channel n |
| ioreq_n | output | 1 | Active-low I/O request, low with an I/O select |
| wait_req | output | 1 | Wait request, high during inserted wait states |

## Verification
Two functions can meet on one clock edge: a register write and the decode of a bus cycle. The bench provokes this by writing channel 1's lower bound on the same edge that samples a memory request. The new bound would exclude the address, so the output after that edge must still show the old selection. The following cycle, with the address unchanged, must show the new one. The overlap of several matching channels is judged the same way: exactly the lowest-numbered select must go low.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int CFG_W   = 8;
    localparam int CTL_EN  = 3;
    localparam int CTL_IO  = 4;
    localparam int WS_LSB  = 5;
    localparam int WS_W    = 3;
    localparam int IO_LSB  = 4;

    localparam logic [1:0] SEL_CTL = 2'd0;
    localparam logic [1:0] SEL_LO  = 2'd1;
    localparam logic [1:0] SEL_HI  = 2'd2;

    typedef struct packed {
        logic [CFG_W-1:0] ctl;
        logic [CFG_W-1:0] lo;
        logic [CFG_W-1:0] hi;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_BOOT = '{ctl: 8'h08, lo: 8'h00, hi: 8'hFF};
    localparam chan_cfg_t CFG_OFF  = '{ctl: 8'h00, lo: 8'h00, hi: 8'h00};
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CH_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [CH_W-1:0]        wr_chan_i,
    input  logic [1:0]             wr_sel_i,
    input  logic [CFG_W-1:0]       wr_data_i,
    output chan_cfg_t [NUM_CS-1:0] cfg_o
);
    chan_cfg_t [NUM_CS-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int c = 0; c < NUM_CS; c++) begin
            if (wr_en_i && wr_chan_i == CH_W'(c)) begin
                case (wr_sel_i)
                    SEL_CTL: cfg_d[c].ctl = wr_data_i;
                    SEL_LO:  cfg_d[c].lo  = wr_data_i;
                    SEL_HI:  cfg_d[c].hi  = wr_data_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CS; c++)
                cfg_q[c] <= (c == 0) ? CFG_BOOT : CFG_OFF;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/csd_chan_match.sv
module csd_chan_match
    import csd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  chan_cfg_t         cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mem_req_i,
    input  logic              io_req_i,
    input  logic              io_instr_i,
    output logic              hit_o,
    output logic              io_o
);
    localparam int PAGE_LSB = ADDR_W - CFG_W;

    logic [CFG_W-1:0] page;
    logic [CFG_W-1:0] io_key;
    logic             periph;
    logic             en;
    logic             io_mode;
    logic             mem_hit;
    logic             io_hit;

    always_comb begin
        page    = addr_i[PAGE_LSB +: CFG_W];
        io_key  = addr_i[IO_LSB +: CFG_W];
        periph  = addr_i[7];
        en      = cfg_i.ctl[CTL_EN];
        io_mode = cfg_i.ctl[CTL_IO];
        mem_hit = mem_req_i && en && !io_mode
                  && (page >= cfg_i.lo) && (page <= cfg_i.hi);
        io_hit  = io_req_i && io_instr_i && en && io_mode
                  && (io_key == cfg_i.lo) && !periph;
        hit_o   = mem_hit || io_hit;
        io_o    = io_hit;
    end
endmodule

// File: rtl/csd_prio_pick.sv
module csd_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        gnt_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/csd_top.sv
module csd_top
    import csd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    localparam int CH_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W+1:0]   wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              io_req,
    input  logic              io_instr,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ioreq_n,
    output logic              wait_req
);
    typedef struct packed {
        logic [NUM_CS-1:0] cs_n;
        logic              ioreq_n;
        logic [WS_W-1:0]   wcnt;
        logic              strb;
    } dec_t;

    chan_cfg_t [NUM_CS-1:0] cfg;
    logic [NUM_CS-1:0]      hit_vec;
    logic [NUM_CS-1:0]      io_vec;
    logic [NUM_CS-1:0]      gnt;
    logic [WS_W-1:0]        ws_sel;
    logic                   io_sel;
    logic                   strb_now;
    dec_t                   st_d, st_q;

    csd_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_chan_i (wr_addr[CH_W+1:2]),
        .wr_sel_i  (wr_addr[1:0]),
        .wr_data_i (wr_data),
        .cfg_o     (cfg)
    );

    for (genvar c = 0; c < NUM_CS; c++) begin : g_chan
        csd_chan_match #(.ADDR_W(ADDR_W)) u_match (
            .cfg_i      (cfg[c]),
            .addr_i     (addr),
            .mem_req_i  (mem_req),
            .io_req_i   (io_req),
            .io_instr_i (io_instr),
            .hit_o      (hit_vec[c]),
            .io_o       (io_vec[c])
        );
    end

    csd_prio_pick #(.N(NUM_CS)) u_pick (
        .req_i (hit_vec),
        .gnt_o (gnt)
    );

    always_comb begin
        ws_sel   = '0;
        io_sel   = 1'b0;
        for (int c = 0; c < NUM_CS; c++) begin
            if (gnt[c]) begin
                ws_sel = ws_sel | cfg[c].ctl[WS_LSB +: WS_W];
                io_sel = io_sel | io_vec[c];
            end
        end
        strb_now     = mem_req || io_req;
        st_d         = st_q;
        st_d.strb    = strb_now;
        st_d.cs_n    = ~gnt;
        st_d.ioreq_n = ~io_sel;
        if (strb_now && !st_q.strb)
            st_d.wcnt = ws_sel;
        else if (st_q.wcnt != '0)
            st_d.wcnt = st_q.wcnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_n    <= '1;
            st_q.ioreq_n <= 1'b1;
            st_q.wcnt    <= '0;
            st_q.strb    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n     = st_q.cs_n;
    assign ioreq_n  = st_q.ioreq_n;
    assign wait_req = (st_q.wcnt != '0);
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_req,
    input logic              io_req,
    input logic              io_instr,
    input logic [NUM_CS-1:0] cs_n,
    input logic              ioreq_n,
    input logic              wait_req
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R6

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req || io_req) |=> (&cs_n && ioreq_n)); // R9

    AST_PERIPH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && addr[7]) |=> &cs_n); // R5

    AST_IOREQ_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !ioreq_n |-> !(&cs_n)); // R7

    AST_IO_NEEDS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !io_instr) |=> &cs_n); // R4

    AST_MEM_NO_IOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !io_req) |=> ioreq_n); // R7
endmodule

bind csd_top csd_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .mem_req  (mem_req),
    .io_req   (io_req),
    .io_instr (io_instr),
    .cs_n     (cs_n),
    .ioreq_n  (ioreq_n),
    .wait_req (wait_req)
);

// File: tb/csd_top_tb_top.sv
module csd_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] addr = '0;
    logic        mem_req = 1'b0;
    logic        io_req = 1'b0;
    logic        io_instr = 1'b0;
    logic [3:0]  cs_n;
    logic        ioreq_n;
    logic        wait_req;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    csd_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .addr     (addr),
        .mem_req  (mem_req),
        .io_req   (io_req),
        .io_instr (io_instr),
        .cs_n     (cs_n),
        .ioreq_n  (ioreq_n),
        .wait_req (wait_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int ch, input int sel, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = {ch[1:0], sel[1:0]};
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic bus(input logic [23:0] a, input logic m, input logic i, input logic ins);
        addr     = a;
        mem_req  = m;
        io_req   = i;
        io_instr = ins;
        step();
    endtask

    task automatic idle();
        bus(24'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 cs_n after reset", cs_n, 4'hF);
        chk("R1 ioreq_n after reset", ioreq_n, 1);
        chk("R1 wait after reset", wait_req, 0);
        bus(24'h123456, 1, 0, 0);
        chk("R1 boot channel 0", cs_n, 4'hE);
        idle();
        chk("R9 idle releases", cs_n, 4'hF);
    endtask

    task automatic t_mem();
        wr(0, 0, 8'h00);
        wr(1, 1, 8'hA0); wr(1, 2, 8'hCF); wr(1, 0, 8'h08);
        wr(2, 1, 8'h00); wr(2, 2, 8'hFF); wr(2, 0, 8'h00);
        bus(24'hA00000, 1, 0, 0);
        chk("R3 lower bound inclusive", cs_n, 4'hD);
        chk("R7 memory select keeps ioreq high", ioreq_n, 1);
        bus(24'hCFFFFF, 1, 0, 0);
        chk("R3 upper bound inclusive", cs_n, 4'hD);
        bus(24'h9FFFFF, 1, 0, 0);
        chk("R2 disabled channels stay high", cs_n, 4'hF);
        bus(24'hD00000, 1, 0, 0);
        chk("R3 above upper bound", cs_n, 4'hF);
        idle();
    endtask

    task automatic t_io();
        wr(3, 1, 8'h12); wr(3, 0, 8'h18);
        bus(24'hAB5120, 0, 1, 1);
        chk("R4 io match ignores high bits", cs_n, 4'h7);
        chk("R7 io select drives ioreq low", ioreq_n, 0);
        bus(24'hAB5120, 0, 1, 0);
        chk("R4 no io instruction", cs_n, 4'hF);
        bus(24'h000120, 1, 0, 0);
        chk("R3 io channel ignores memory cycle", cs_n, 4'hF);
        wr(3, 1, 8'h1A);
        bus(24'h0001A5, 0, 1, 1);
        chk("R5 peripheral window suppresses", cs_n, 4'hF);
        chk("R5 ioreq stays high", ioreq_n, 1);
        idle();
    endtask

    task automatic t_prio();
        wr(1, 1, 8'h00); wr(1, 2, 8'hFF);
        wr(2, 0, 8'h08);
        bus(24'h500000, 1, 0, 0);
        chk("R6 lowest channel wins memory", cs_n, 4'hD);
        wr(1, 0, 8'h00);
        bus(24'h500000, 1, 0, 0);
        chk("R6 next channel after disable", cs_n, 4'hB);
        wr(2, 1, 8'h12); wr(2, 0, 8'h18);
        wr(3, 1, 8'h12);
        bus(24'h000120, 0, 1, 1);
        chk("R6 lowest channel wins io", cs_n, 4'hB);
        wr(3, 3, 8'hFF);
        bus(24'h000120, 0, 1, 1);
        chk("R10 register code 3 ignored", cs_n, 4'hB);
        idle();
    endtask

    task automatic t_wait();
        wr(1, 0, 8'h68);
        idle();
        bus(24'h400000, 1, 0, 0);
        chk("R8 wait cycle 1", wait_req, 1);
        step();
        chk("R8 wait cycle 2", wait_req, 1);
        step();
        chk("R8 wait cycle 3", wait_req, 1);
        step();
        chk("R8 wait released", wait_req, 0);
        idle();
        wr(1, 0, 8'h08);
        bus(24'h400000, 1, 0, 0);
        chk("R8 zero count no wait", wait_req, 0);
        chk("R8 select with zero count", cs_n, 4'hD);
        idle();
    endtask

    task automatic t_same();
        wr(1, 1, 8'hA0); wr(1, 2, 8'hCF);
        wr_en    = 1'b1;
        wr_addr  = {2'd1, 2'd1};
        wr_data  = 8'hB0;
        addr     = 24'hA50000;
        mem_req  = 1'b1;
        step();
        wr_en    = 1'b0;
        chk("R10 decode uses prior config", cs_n, 4'hD);
        step();
        chk("R10 later decode uses new config", cs_n, 4'hF);
        idle();
        chk("R9 release after strobe drop", cs_n, 4'hF);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3;
        step();
        step();
        rst_n = 1'b1;
        #1;
        t_reset();
        t_mem();
        t_io();
        t_prio();
        t_wait();
        t_same();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule